// File: doc/BRIEF.md
# Streaming Debug Capture Unit

This block watches a wide bus of internal probe signals, split into equal-width groups, and turns a chosen group into a stream of timestamped sample words. A trigger built from match terms on a fixed subset of the probe bits starts recording. A qualification filter keeps only the cycles of interest, such as cycles where a bus carries traffic. Recorded words go into a local FIFO. The FIFO drains through a valid/ready output stream toward a fast serial link.

Two recording modes exist. In streaming mode, recording continues after the start condition until an optional length is reached. If the FIFO is full, samples are dropped and recording picks up again by itself, with the first word after the gap marked. In burst mode, each accepted trigger records a fixed-size chunk whose room in the FIFO is checked before the trigger is taken. Either mode can stop after one start or re-arm itself after every capture.

Configuration uses a small register-write port that only works while the unit is disarmed. Separate arm and disarm pulses start and stop trigger evaluation.

Top module: `stream_capture_unit`

## Requirements
- R1: Only probe bits set in the parameter `TRIG_SRC` can take part in the trigger. Trigger-enable bits outside that set have no effect.
- R2: The AND term is true when every effective enabled bit equals its compare bit; with no enabled bit it is true. The OR term is true when any effective enabled bit matches; with no enabled bit it is false. Mode bits [1:0] pick the trigger: 0 = AND term, 1 = OR term, 2 = both, 3 = either.
- R3: Mode bit 3 set makes the unit return to waiting for a trigger after each capture. When it is clear, the unit disarms (`armed_o` low) after one capture.
- R4: The qualification register pair (mask at address 2, value at address 3) restricts writes to cycles where the masked bits of the selected group equal the value. A zero mask qualifies every cycle.
- R5: Mode bits [9:8] select the probe group that is qualified and recorded. Group g is probe bits [8g+7:8g].
- R6: Each FIFO word is {gap[16], timestamp[15:8], data[7:0]}. The timestamp is 0 in the first cycle after arm and goes up by one every armed cycle. The cycle in which a trigger fires is itself a candidate sample.
- R7: Mode bit 2 selects burst mode. Each accepted trigger writes exactly length-register (address 5) qualified samples. A trigger condition seen during a burst is ignored.
- R8: A burst trigger is accepted only if the free FIFO space is at least the burst size. A length of 0 or a length above the FIFO depth means the FIFO depth.
- R9: In streaming mode, a qualified sample that meets a full FIFO is dropped and sets sticky `overflow_o`. The next word written carries gap = 1.
- R10: In streaming mode, a nonzero length ends the capture after that many written words. A length of 0 never ends it.
- R11: Configuration writes are ignored while armed. An arm pulse in the disarmed state clears `triggered_o` and `overflow_o`. A disarm pulse stops recording in that same cycle.
- R12: After reset the unit is disarmed, all status outputs are low and the stream is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| probe_i | input | 32 | Probed signals, four groups of 8 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Register address: 0 trigger enable, 1 compare, 2 qualify mask, 3 qualify value, 4 mode, 5 length |
| cfg_wdata_i | input | 32 | Configuration write data |
| arm_i | input | 1 | Arm pulse |
| disarm_i | input | 1 | Disarm pulse |
| m_valid_o | output | 1 | Output word valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | 17 | Output word {gap, timestamp, data} |
| armed_o | output | 1 | Unit armed |
| triggered_o | output | 1 | Sticky: a start condition occurred since arm |
| overflow_o | output | 1 | Sticky: a streaming sample was dropped since arm |

## Verification
The assertions assume that arm and disarm are single-cycle pulses that are never high together. They also assume that the consumer holds its ready signal so the FIFO pops only when the word is valid, and that the FIFO depth is a power of two. The bench drives every command for one cycle at the falling edge, never asserts arm and disarm together, and changes configuration only after a disarm pulse. Within those limits, the stream-hold and sticky-overflow properties depend only on the design.

// File: rtl/dcu_pkg.sv
package dcu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2
  } cap_state_e;

  typedef enum logic [1:0] {
    CMB_AND    = 2'd0,
    CMB_OR     = 2'd1,
    CMB_BOTH   = 2'd2,
    CMB_EITHER = 2'd3
  } trig_comb_e;

  localparam logic [2:0] ADDR_TRIG_EN  = 3'd0;
  localparam logic [2:0] ADDR_TRIG_VAL = 3'd1;
  localparam logic [2:0] ADDR_QUAL_MSK = 3'd2;
  localparam logic [2:0] ADDR_QUAL_VAL = 3'd3;
  localparam logic [2:0] ADDR_MODE     = 3'd4;
  localparam logic [2:0] ADDR_LENGTH   = 3'd5;

  localparam int unsigned MODE_BURST_BIT  = 2;
  localparam int unsigned MODE_REPEAT_BIT = 3;
  localparam int unsigned MODE_GSEL_LSB   = 8;

endpackage

// File: rtl/dcu_cfg.sv
module dcu_cfg
  import dcu_pkg::*;
#(
  parameter int unsigned PROBE_W = 32,
  parameter int unsigned GROUP_W = 8,
  parameter int unsigned GSEL_W  = 2,
  parameter int unsigned LEN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [PROBE_W-1:0] wdata_i,
  output logic [PROBE_W-1:0] trig_en_o,
  output logic [PROBE_W-1:0] trig_val_o,
  output logic [GROUP_W-1:0] qual_msk_o,
  output logic [GROUP_W-1:0] qual_val_o,
  output trig_comb_e         comb_o,
  output logic               burst_o,
  output logic               repeat_o,
  output logic [GSEL_W-1:0]  gsel_o,
  output logic [LEN_W-1:0]   len_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_en_o  <= '0;
      trig_val_o <= '0;
      qual_msk_o <= '0;
      qual_val_o <= '0;
      comb_o     <= CMB_AND;
      burst_o    <= 1'b0;
      repeat_o   <= 1'b0;
      gsel_o     <= '0;
      len_o      <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_TRIG_EN:  trig_en_o  <= wdata_i;
        ADDR_TRIG_VAL: trig_val_o <= wdata_i;
        ADDR_QUAL_MSK: qual_msk_o <= wdata_i[GROUP_W-1:0];
        ADDR_QUAL_VAL: qual_val_o <= wdata_i[GROUP_W-1:0];
        ADDR_MODE: begin
          comb_o   <= trig_comb_e'(wdata_i[1:0]);
          burst_o  <= wdata_i[MODE_BURST_BIT];
          repeat_o <= wdata_i[MODE_REPEAT_BIT];
          gsel_o   <= wdata_i[MODE_GSEL_LSB +: GSEL_W];
        end
        ADDR_LENGTH:   len_o <= wdata_i[LEN_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dcu_trigger.sv
module dcu_trigger
  import dcu_pkg::*;
#(
  parameter int unsigned        PROBE_W  = 32,
  parameter logic [PROBE_W-1:0] TRIG_SRC = '1
) (
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [PROBE_W-1:0] en_i,
  input  logic [PROBE_W-1:0] val_i,
  input  trig_comb_e         comb_i,
  output logic               hit_o
);

  logic [PROBE_W-1:0] eff_en;
  logic [PROBE_W-1:0] match;
  logic               and_term;
  logic               or_term;

  assign eff_en   = en_i & TRIG_SRC;
  assign match    = ~(probe_i ^ val_i);
  assign and_term = &(match | ~eff_en);
  assign or_term  = |(match & eff_en);

  always_comb begin
    case (comb_i)
      CMB_AND:    hit_o = and_term;
      CMB_OR:     hit_o = or_term;
      CMB_BOTH:   hit_o = and_term & or_term;
      CMB_EITHER: hit_o = and_term | or_term;
      default:    hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dcu_fifo.sv
module dcu_fifo #(
  parameter int unsigned W     = 17,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         full_o,
  output logic [AW:0]  count_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          push_ok, pop_ok;

  assign valid_o = (count_o != '0);
  assign full_o  = (count_o == (AW+1)'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && valid_o;
  assign data_o  = mem[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
      count_o <= count_o + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

endmodule

// File: rtl/stream_capture_unit.sv
module stream_capture_unit
  import dcu_pkg::*;
#(
  parameter int unsigned N_GROUPS   = 4,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned TS_W       = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LEN_W      = 16,
  parameter logic [N_GROUPS*GROUP_W-1:0] TRIG_SRC = (N_GROUPS*GROUP_W)'(16'hFFFF),
  localparam int unsigned PROBE_W = N_GROUPS * GROUP_W,
  localparam int unsigned WORD_W  = 1 + TS_W + GROUP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_addr_i,
  input  logic [PROBE_W-1:0] cfg_wdata_i,
  input  logic               arm_i,
  input  logic               disarm_i,
  output logic               m_valid_o,
  input  logic               m_ready_i,
  output logic [WORD_W-1:0]  m_data_o,
  output logic               armed_o,
  output logic               triggered_o,
  output logic               overflow_o
);

  localparam int unsigned GSEL_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam int unsigned AW     = $clog2(FIFO_DEPTH);

  cap_state_e         state_q, state_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [TS_W-1:0]    ts_q;
  logic               gap_q;

  logic [PROBE_W-1:0] trig_en, trig_val;
  logic [GROUP_W-1:0] qual_msk, qual_val;
  trig_comb_e         comb;
  logic               burst_mode, repeat_mode;
  logic [GSEL_W-1:0]  gsel;
  logic [LEN_W-1:0]   len_cfg;

  logic               hit, accept, start, sampling, qual, want, last;
  logic               fifo_push, fifo_drop, fifo_full;
  logic [AW:0]        fifo_cnt;
  logic [LEN_W-1:0]   limit;
  logic [GROUP_W-1:0] grp_data;
  logic [GROUP_W-1:0] grp [N_GROUPS];
  logic               arm_ok;

  dcu_cfg #(
    .PROBE_W(PROBE_W), .GROUP_W(GROUP_W), .GSEL_W(GSEL_W), .LEN_W(LEN_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i && (state_q == ST_IDLE)),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .trig_en_o  (trig_en),
    .trig_val_o (trig_val),
    .qual_msk_o (qual_msk),
    .qual_val_o (qual_val),
    .comb_o     (comb),
    .burst_o    (burst_mode),
    .repeat_o   (repeat_mode),
    .gsel_o     (gsel),
    .len_o      (len_cfg)
  );

  dcu_trigger #(.PROBE_W(PROBE_W), .TRIG_SRC(TRIG_SRC)) u_trig (
    .probe_i (probe_i),
    .en_i    (trig_en),
    .val_i   (trig_val),
    .comb_i  (comb),
    .hit_o   (hit)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp[g] = probe_i[g*GROUP_W +: GROUP_W];
  end

  assign grp_data = (gsel <= GSEL_W'(N_GROUPS - 1)) ? grp[gsel] : '0;
  assign qual     = ((grp_data ^ qual_val) & qual_msk) == '0;

  // burst size saturates at the FIFO depth; zero means a full FIFO
  always_comb begin
    if (burst_mode) begin
      if (len_cfg == '0 || len_cfg > LEN_W'(FIFO_DEPTH)) limit = LEN_W'(FIFO_DEPTH);
      else                                               limit = len_cfg;
    end else begin
      limit = len_cfg;
    end
  end

  assign accept   = !burst_mode ||
                    ((LEN_W'(FIFO_DEPTH) - LEN_W'(fifo_cnt)) >= limit);
  assign start    = (state_q == ST_WAIT) && !disarm_i && hit && accept;
  assign sampling = start || ((state_q == ST_CAP) && !disarm_i);
  assign want     = sampling && qual;
  assign fifo_push = want && !fifo_full;
  assign fifo_drop = want && fifo_full;
  assign last     = fifo_push && (limit != '0) && ((cnt_q + LEN_W'(1)) == limit);
  assign arm_ok   = arm_i && !disarm_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (arm_ok) begin
        state_d = ST_WAIT;
        cnt_d   = '0;
      end
      ST_WAIT: if (start) begin
        state_d = ST_CAP;
        cnt_d   = LEN_W'(fifo_push);
      end
      ST_CAP:  cnt_d = cnt_q + LEN_W'(fifo_push);
      default: state_d = ST_IDLE;
    endcase
    if (last) begin
      state_d = repeat_mode ? ST_WAIT : ST_IDLE;
      cnt_d   = '0;
    end
    if (disarm_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      ts_q        <= '0;
      gap_q       <= 1'b0;
      triggered_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (arm_ok) begin
        ts_q        <= '0;
        gap_q       <= 1'b0;
        triggered_o <= 1'b0;
        overflow_o  <= 1'b0;
      end else begin
        if (state_q != ST_IDLE) ts_q <= ts_q + TS_W'(1);
        if (start) triggered_o <= 1'b1;
        if (fifo_drop) begin
          overflow_o <= 1'b1;
          gap_q      <= 1'b1;
        end else if (fifo_push) begin
          gap_q      <= 1'b0;
        end
      end
    end
  end

  dcu_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .data_i  ({gap_q, ts_q, grp_data}),
    .pop_i   (m_ready_i),
    .data_o  (m_data_o),
    .valid_o (m_valid_o),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );

  assign armed_o = (state_q != ST_IDLE);

endmodule

// File: rtl/dcu_checker.sv
module dcu_checker #(
  parameter int unsigned WORD_W  = 17,
  parameter int unsigned PROBE_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               arm_i,
  input logic               armed_o,
  input logic               triggered_o,
  input logic               overflow_o,
  input logic               m_valid_o,
  input logic               m_ready_i,
  input logic [WORD_W-1:0]  m_data_o,
  input logic               push_i,
  input logic               drop_i,
  input logic               full_i,
  input logic               burst_i,
  input logic [PROBE_W-1:0] trig_val_i
);

  // R9: a word is never written into a full FIFO
  a_r9_push_needs_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_i);

  // R8: reserved room means a burst never drops
  a_r8_burst_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |-> !burst_i);

  // R11: arming clears the sticky status
  a_r11_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !armed_o) |=> (!triggered_o && !overflow_o));

  // R11: settings frozen while armed
  a_r11_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> $stable(trig_val_i));

  // R6: an unaccepted word holds
  a_r6_stream_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));

  // R9: overflow stays set until a new arm
  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !(arm_i && !armed_o)) |=> overflow_o);

endmodule

bind stream_capture_unit dcu_checker #(.WORD_W(WORD_W), .PROBE_W(PROBE_W)) u_dcu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .armed_o     (armed_o),
  .triggered_o (triggered_o),
  .overflow_o  (overflow_o),
  .m_valid_o   (m_valid_o),
  .m_ready_i   (m_ready_i),
  .m_data_o    (m_data_o),
  .push_i      (fifo_push),
  .drop_i      (fifo_drop),
  .full_i      (fifo_full),
  .burst_i     (burst_mode),
  .trig_val_i  (trig_val)
);

// File: tb/stream_capture_unit_test.sv
module stream_capture_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] probe_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        arm_i = 1'b0;
  logic        disarm_i = 1'b0;
  logic        m_valid_o;
  logic        m_ready_i = 1'b0;
  logic [16:0] m_data_o;
  logic        armed_o, triggered_o, overflow_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stream_capture_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .probe_i(probe_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .arm_i(arm_i), .disarm_i(disarm_i),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o),
    .armed_o(armed_o), .triggered_o(triggered_o), .overflow_o(overflow_o)
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] val;
    logic [1:0]  comb;
    logic [31:0] probe;
    logic        hit;
  } tvec_t;

  // R1/R2 trigger vectors; trigger sources are probe bits [15:0]
  localparam tvec_t TV [10] = '{
    '{32'h0000_00FF, 32'h0000_00A5, 2'd0, 32'h0000_00A5, 1'b1},
    '{32'h0000_00FF, 32'h0000_00A5, 2'd0, 32'h0000_00A4, 1'b0},
    '{32'h0000_00FF, 32'h0000_00A5, 2'd1, 32'h0000_005A, 1'b0},
    '{32'h0000_00FF, 32'h0000_00A5, 2'd1, 32'h0000_00A4, 1'b1},
    '{32'h0000_00FF, 32'h0000_00A5, 2'd2, 32'h0000_00A5, 1'b1},
    '{32'h0000_00FF, 32'h0000_00A5, 2'd2, 32'h0000_00A4, 1'b0},
    '{32'h0000_00FF, 32'h0000_00A5, 2'd3, 32'h0000_00A4, 1'b1},
    '{32'h0000_00FF, 32'h0000_00A5, 2'd3, 32'h0000_005A, 1'b0},
    '{32'h00FF_0000, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0},
    '{32'hFF00_0000, 32'h0000_0000, 2'd0, 32'hFFFF_FFFF, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic do_arm();
    arm_i = 1'b1; tick(); arm_i = 1'b0;
  endtask

  task automatic do_disarm();
    disarm_i = 1'b1; tick(); disarm_i = 1'b0;
  endtask

  task automatic flush();
    m_ready_i = 1'b1;
    repeat (20) tick();
    m_ready_i = 1'b0;
  endtask

  task automatic pop_expect(string req, logic [16:0] exp);
    check(req, {31'd0, m_valid_o}, 32'd1);
    check(req, {15'd0, m_data_o}, {15'd0, exp});
    m_ready_i = 1'b1; tick(); m_ready_i = 1'b0;
  endtask

  function automatic logic [16:0] word(logic g, logic [7:0] ts, logic [7:0] d);
    return {g, ts, d};
  endfunction

  task automatic config_all(logic [31:0] en, logic [31:0] val, logic [31:0] mode,
                            logic [31:0] len, logic [7:0] qm, logic [7:0] qv);
    cfg_write(3'd0, en);
    cfg_write(3'd1, val);
    cfg_write(3'd2, {24'd0, qm});
    cfg_write(3'd3, {24'd0, qv});
    cfg_write(3'd4, mode);
    cfg_write(3'd5, len);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] bseq [22];
    int         bexp [16];
    bseq = '{8'h55, 8'h55, 8'h01, 8'h02, 8'h03, 8'h55, 8'h10, 8'h11, 8'h12, 8'h04, 8'h55,
             8'h20, 8'h21, 8'h22, 8'h55, 8'h30, 8'h31, 8'h32, 8'h55, 8'h40, 8'h41, 8'h42};
    bexp = '{0, 1, 2, 3, 5, 6, 7, 8, 10, 11, 12, 13, 14, 15, 16, 17};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();

    // R12 reset state
    check("R12 armed", {31'd0, armed_o}, 32'd0);
    check("R12 triggered", {31'd0, triggered_o}, 32'd0);
    check("R12 overflow", {31'd0, overflow_o}, 32'd0);
    check("R12 valid", {31'd0, m_valid_o}, 32'd0);

    // R1 R2 R3: trigger table, single-shot streaming with length 1
    m_ready_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      do_disarm();
      config_all(TV[i].en, TV[i].val, {30'd0, TV[i].comb}, 32'd1, 8'h00, 8'h00);
      probe_i = TV[i].probe;
      do_arm();
      tick();
      check((i >= 8) ? "R1 trigger source" : "R2 trigger hit",
            {31'd0, triggered_o}, {31'd0, TV[i].hit});
      check("R3 single shot disarms", {31'd0, armed_o}, {31'd0, !TV[i].hit});
    end
    do_disarm();
    flush();

    // R11: config writes ignored while armed
    config_all(32'h0000_00FF, 32'h0000_0011, 32'd0, 32'd1, 8'h00, 8'h00);
    probe_i = 32'h0;
    do_arm();
    cfg_write(3'd1, 32'h0000_0022);
    probe_i = 32'h0000_0022;
    tick();
    check("R11 write while armed ignored", {31'd0, triggered_o}, 32'd0);
    probe_i = 32'h0000_0011;
    tick();
    check("R11 original compare kept", {31'd0, triggered_o}, 32'd1);
    do_disarm();
    flush();

    // R3 R10: repeat mode, length 1 per start
    config_all(32'h0000_00FF, 32'h0000_0055, 32'h8, 32'd1, 8'h00, 8'h00);
    probe_i = 32'h0;
    do_arm();
    probe_i = 32'h55; tick();
    probe_i = 32'h00; tick();
    probe_i = 32'h55; tick();
    probe_i = 32'h00; tick();
    check("R3 repeat stays armed", {31'd0, armed_o}, 32'd1);
    do_disarm();
    pop_expect("R10 first start one word", word(1'b0, 8'd0, 8'h55));
    pop_expect("R3 re-armed second start", word(1'b0, 8'd2, 8'h55));
    check("R10 no extra words", {31'd0, m_valid_o}, 32'd0);

    // R4 R5 R6: qualification on group 2, immediate start, unlimited length
    config_all(32'h0, 32'h0, 32'h200, 32'd0, 8'h80, 8'h80);
    probe_i = 32'h0;
    do_arm();
    probe_i = {8'h11, 8'h81, 8'h22, 8'hEE}; tick();
    probe_i = {8'h11, 8'h01, 8'h22, 8'hEE}; tick();
    probe_i = {8'h11, 8'h82, 8'h22, 8'hEE}; tick();
    probe_i = {8'h11, 8'h83, 8'h22, 8'hEE}; tick();
    probe_i = {8'h11, 8'h02, 8'h22, 8'hEE}; tick();
    do_disarm();
    pop_expect("R5 group 2 sampled", word(1'b0, 8'd0, 8'h81));
    pop_expect("R4 unqualified cycle skipped", word(1'b0, 8'd2, 8'h82));
    pop_expect("R6 timestamp advances", word(1'b0, 8'd3, 8'h83));
    check("R4 final unqualified dropped", {31'd0, m_valid_o}, 32'd0);

    // R9: streaming overflow, drop, gap mark
    config_all(32'h0, 32'h0, 32'h0, 32'd0, 8'h00, 8'h00);
    probe_i = 32'h0;
    do_arm();
    for (int k = 0; k < 20; k++) begin
      probe_i = k;
      tick();
    end
    check("R9 overflow set", {31'd0, overflow_o}, 32'd1);
    probe_i = 32'd20; m_ready_i = 1'b1; tick();
    m_ready_i = 1'b0;
    probe_i = 32'd21; tick();
    do_disarm();
    for (int k = 1; k < 16; k++) begin
      pop_expect("R9 words before gap", word(1'b0, 8'(k), 8'(k)));
    end
    pop_expect("R9 gap flag after resume", word(1'b1, 8'd21, 8'd21));
    check("R9 nothing after gap word", {31'd0, m_valid_o}, 32'd0);
    do_arm();
    check("R11 arm clears overflow", {31'd0, overflow_o}, 32'd0);
    check("R11 arm clears triggered", {31'd0, triggered_o}, 32'd0);
    do_disarm();
    flush();

    // R7 R8: repeating bursts of 4, room check at the fifth trigger
    config_all(32'h0000_00FF, 32'h0000_0055, 32'hC, 32'd4, 8'h00, 8'h00);
    probe_i = 32'h0;
    do_arm();
    for (int i = 0; i < 22; i++) begin
      probe_i = {24'd0, bseq[i]};
      tick();
    end
    do_disarm();
    for (int j = 0; j < 16; j++) begin
      pop_expect("R7 burst contents", word(1'b0, 8'(bexp[j]), bseq[bexp[j]]));
    end
    check("R8 burst refused without room", {31'd0, m_valid_o}, 32'd0);

    // R8: length 0 in burst means FIFO depth, single shot
    config_all(32'h0, 32'h0, 32'h4, 32'd0, 8'h00, 8'h00);
    probe_i = 32'h0;
    do_arm();
    repeat (20) tick();
    check("R8 single burst done", {31'd0, armed_o}, 32'd0);
    for (int j = 0; j < 16; j++) begin
      pop_expect("R8 full-depth burst", word(1'b0, 8'(j), 8'h00));
    end
    check("R8 burst size equals depth", {31'd0, m_valid_o}, 32'd0);

    finish_run();
  end

endmodule